// File: doc/BRIEF.md
# Command-Sequence Write Protection Unit

This unit sits in the write path of a byte-addressed non-volatile memory front end, between the strobe capture logic and the page write controller. For every captured write strobe it gives a verdict in the same cycle. A write is either permitted, which means the page controller stores the byte, or discarded, which means it was a command byte and is not stored. A write can also be neither, which means it is blocked. The unit watches the strobe stream for fixed address/data command sequences. These sequences turn the protection flag on or off, or open a short unlocked page-load session while protection is on.

Arming and unlocking use the same three-write prefix. Disarming takes a six-write sequence. Each byte in a sequence, and each data byte in an unlocked session, must arrive within a byte-load window of the previous strobe. Otherwise the partial sequence or the session is dropped. The protection flag has its own cold reset and is not cleared by the write-path reset. This models a flag that survives power loss. The flag is clear after a cold reset.

Top module: `cmd_write_guard`

## Requirements
- R1: After cold and write-path reset, `protActive` and `pageUnlocked` are 0, and a plain write strobe gives `wrPermit`=1.
- R2: While unprotected, a strobe whose address/data does not match the expected next command byte gives `wrPermit`=1 and `wrDiscard`=0 in the strobe cycle.
- R3: The arm/unlock prefix is data 0xAA at address 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555. On the clock edge that accepts the third byte, `protActive` becomes 1 and `pageUnlocked` becomes 1, whether or not data writes follow.
- R4: Every strobe that matches the expected next command byte gives `wrDiscard`=1 and `wrPermit`=0. `wrPermit` and `wrDiscard` are never 1 together.
- R5: While `protActive`=1 and `pageUnlocked`=0, a non-command strobe gives `wrPermit`=0 and `wrDiscard`=0.
- R6: While `pageUnlocked`=1, every non-command strobe gives `wrPermit`=1, for any number of bytes in the session.
- R7: A one-cycle `pgmStart` pulse clears `pageUnlocked` on the next edge, and later plain writes are blocked while protected.
- R8: With `BLC_CYCLES`=N, a strobe that comes N cycles after the previous one is still in the window. If N+1 or more cycles pass, a partial sequence returns to idle and an open session closes.
- R9: The disarm sequence is 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555. All six bytes are discarded. The edge that accepts the sixth byte clears `protActive`, and later plain writes are permitted.
- R10: A strobe that does not match the expected next command byte returns the matcher to idle. That strobe is then handled as a plain write under the current protection state, and a new sequence must start again from its first byte.
- R11: Asserting `rstN` alone leaves `protActive` unchanged. Asserting `coldRstN` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Active-low cold reset; clears the protection flag |
| rstN | input | 1 | Active-low write-path reset; clears matcher, session and timer |
| wrStrobe | input | 1 | One-cycle pulse per captured write |
| wrAddr | input | 13 | Captured write address |
| wrData | input | 8 | Captured write data |
| pgmStart | input | 1 | Pulse from the page controller when its program cycle begins |
| wrPermit | output | 1 | Store this strobe's byte |
| wrDiscard | output | 1 | This strobe was a command byte; do not store it |
| protActive | output | 1 | Protection flag |
| pageUnlocked | output | 1 | An unlocked page-load session is open |

## Verification
The bench runs the complete arm and disarm sequences, which show that the matcher's step order and the flag transitions are right. It also runs a sequence broken by a wrong data byte and a command byte sent out of order. These two separate "back to idle and treat as a plain write" from "skip ahead" and from "discard anyway". Strobe gaps of exactly N and N+1 cycles pin the window boundary to one cycle. A page-start pulse and a warm reset, each run in the protected state, show which events end a session and which events leave the flag untouched.

// File: rtl/cmd_write_guard_pkg.sv
package cmd_write_guard_pkg;

  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 8;
  localparam int SEQ_LEN  = 6;
  localparam int STEP_W   = $clog2(SEQ_LEN + 1);
  localparam int HIT_W    = 1 << STEP_W;

  localparam logic [ADDR_W-1:0] CMD_ADDR_HI = 13'h1555;
  localparam logic [ADDR_W-1:0] CMD_ADDR_LO = 13'h0AAA;
  localparam logic [DATA_W-1:0] UNLOCK_DATA = 8'hA0;
  localparam logic [STEP_W-1:0] FORK_STEP   = STEP_W'(2);
  localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(SEQ_LEN - 1);

  typedef logic [STEP_W-1:0] step_t;

  typedef struct packed {
    logic timerClear;
    logic timerRun;
  } ctrl_strobes_t;

  function automatic logic [ADDR_W-1:0] seqAddr(input int idx);
    case (idx)
      1, 4:    seqAddr = CMD_ADDR_LO;
      default: seqAddr = CMD_ADDR_HI;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] seqData(input int idx);
    case (idx)
      0, 3:    seqData = 8'hAA;
      1, 4:    seqData = 8'h55;
      2:       seqData = 8'h80;
      default: seqData = 8'h20;
    endcase
  endfunction

endpackage

// File: rtl/wp_match_datapath.sv
module wp_match_datapath
  import cmd_write_guard_pkg::*;
#(
  parameter int BLC_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  step_t             curStep,
  input  ctrl_strobes_t     strb,
  output logic              stepHit,
  output logic              unlockHit,
  output logic              windowExpired
);

  localparam int CNT_W = $clog2(BLC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLC_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(BLC_CYCLES);

  logic [HIT_W-1:0] hitVec;
  logic [CNT_W-1:0] gapCnt;

  // One comparator per sequence position; unused step codes never hit.
  for (genvar i = 0; i < HIT_W; i++) begin : g_cmp
    if (i < SEQ_LEN) begin : g_used
      assign hitVec[i] = (wrAddr == seqAddr(i)) && (wrData == seqData(i));
    end else begin : g_spare
      assign hitVec[i] = 1'b0;
    end
  end

  assign stepHit   = hitVec[curStep];
  assign unlockHit = (wrAddr == CMD_ADDR_HI) && (wrData == UNLOCK_DATA);

  // Cycles elapsed since the last strobe while a sequence or session is live.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strb.timerClear) begin
      gapCnt <= '0;
    end else if (strb.timerRun && gapCnt != CNT_MAX) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assign windowExpired = strb.timerRun && !strb.timerClear && (gapCnt == CNT_LAST);

endmodule

// File: rtl/wp_seq_control.sv
module wp_seq_control
  import cmd_write_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          coldRstN,
  input  logic          wrStrobe,
  input  logic          pgmStart,
  input  logic          stepHit,
  input  logic          unlockHit,
  input  logic          windowExpired,
  output step_t         curStep,
  output ctrl_strobes_t strb,
  output logic          wrPermit,
  output logic          wrDiscard,
  output logic          protActive,
  output logic          pageUnlocked
);

  logic atFork;
  logic isCmd;
  logic unlockDone;
  logic disableDone;
  logic seqLive;

  assign atFork      = (curStep == FORK_STEP);
  assign isCmd       = wrStrobe && (stepHit || (atFork && unlockHit));
  assign unlockDone  = wrStrobe && atFork && unlockHit;
  assign disableDone = wrStrobe && (curStep == LAST_STEP) && stepHit;
  assign seqLive     = (curStep != '0) || pageUnlocked;

  assign strb.timerRun   = seqLive;
  assign strb.timerClear = wrStrobe || !seqLive;

  assign wrDiscard = isCmd;
  assign wrPermit  = wrStrobe && !isCmd && (!protActive || pageUnlocked);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curStep <= '0;
    end else if (windowExpired) begin
      curStep <= '0;
    end else if (wrStrobe) begin
      if (!isCmd || unlockDone || disableDone) begin
        curStep <= '0;
      end else begin
        curStep <= curStep + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageUnlocked <= 1'b0;
    end else if (unlockDone) begin
      pageUnlocked <= 1'b1;
    end else if (disableDone || windowExpired || pgmStart) begin
      pageUnlocked <= 1'b0;
    end
  end

  // Survives the write-path reset; only a cold reset clears it.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      protActive <= 1'b0;
    end else if (unlockDone) begin
      protActive <= 1'b1;
    end else if (disableDone) begin
      protActive <= 1'b0;
    end
  end

endmodule

// File: rtl/cmd_write_guard.sv
module cmd_write_guard
  import cmd_write_guard_pkg::*;
#(
  parameter int BLC_CYCLES = 5000
) (
  input  logic        clk,
  input  logic        coldRstN,
  input  logic        rstN,
  input  logic        wrStrobe,
  input  logic [12:0] wrAddr,
  input  logic [7:0]  wrData,
  input  logic        pgmStart,
  output logic        wrPermit,
  output logic        wrDiscard,
  output logic        protActive,
  output logic        pageUnlocked
);

  step_t         curStep;
  ctrl_strobes_t strb;
  logic          stepHit;
  logic          unlockHit;
  logic          windowExpired;

  wp_match_datapath #(.BLC_CYCLES(BLC_CYCLES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .curStep      (curStep),
    .strb         (strb),
    .stepHit      (stepHit),
    .unlockHit    (unlockHit),
    .windowExpired(windowExpired)
  );

  wp_seq_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .coldRstN     (coldRstN),
    .wrStrobe     (wrStrobe),
    .pgmStart     (pgmStart),
    .stepHit      (stepHit),
    .unlockHit    (unlockHit),
    .windowExpired(windowExpired),
    .curStep      (curStep),
    .strb         (strb),
    .wrPermit     (wrPermit),
    .wrDiscard    (wrDiscard),
    .protActive   (protActive),
    .pageUnlocked (pageUnlocked)
  );

endmodule

// File: rtl/cmd_write_guard_checker.sv
module cmd_write_guard_checker #(
  parameter int BLC_CYCLES = 5000
) (
  input logic        clk,
  input logic        coldRstN,
  input logic        rstN,
  input logic        wrStrobe,
  input logic [12:0] wrAddr,
  input logic [7:0]  wrData,
  input logic        pgmStart,
  input logic        wrPermit,
  input logic        wrDiscard,
  input logic        protActive,
  input logic        pageUnlocked
);

  localparam int GW = $clog2(BLC_CYCLES + 2);
  localparam logic [GW-1:0] GMAX = GW'(BLC_CYCLES);

  logic [GW-1:0] sinceStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStrobe <= '0;
    end else if (wrStrobe) begin
      sinceStrobe <= '0;
    end else if (sinceStrobe != GMAX) begin
      sinceStrobe <= sinceStrobe + 1'b1;
    end
  end

  // R4: a verdict is never both store and drop
  a_r4_exclusive_verdict: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    !(wrPermit && wrDiscard));

  // R3: the flag only rises on the edge accepting the unlock byte
  a_r3_arm_on_third: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    $rose(protActive) |-> $past(wrStrobe && wrAddr == 13'h1555 && wrData == 8'hA0));

  // R9: the flag only falls on the edge accepting the last disarm byte
  a_r9_disarm_on_sixth: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    $fell(protActive) |-> $past(wrStrobe && wrAddr == 13'h1555 && wrData == 8'h20));

  // R6: an open session implies the flag is set
  a_r6_session_needs_flag: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    pageUnlocked |-> protActive);

  // R7: a page-start pulse ends the session
  a_r7_pgm_closes: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    (pgmStart && !wrStrobe) |=> !pageUnlocked);

  // R8: a session never outlives the byte-load window
  a_r8_window: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    pageUnlocked |-> (sinceStrobe < GMAX));

endmodule

bind cmd_write_guard cmd_write_guard_checker #(.BLC_CYCLES(BLC_CYCLES)) u_chk (
  .clk         (clk),
  .coldRstN    (coldRstN),
  .rstN        (rstN),
  .wrStrobe    (wrStrobe),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .pgmStart    (pgmStart),
  .wrPermit    (wrPermit),
  .wrDiscard   (wrDiscard),
  .protActive  (protActive),
  .pageUnlocked(pageUnlocked)
);

// File: tb/cmd_write_guard_test.sv
module cmd_write_guard_test;

  localparam int BLC = 24;

  logic        clk = 1'b0;
  logic        coldRstN = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        pgmStart = 1'b0;
  logic        wrPermit;
  logic        wrDiscard;
  logic        protActive;
  logic        pageUnlocked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmd_write_guard #(.BLC_CYCLES(BLC)) uut (
    .clk(clk), .coldRstN(coldRstN), .rstN(rstN), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrData(wrData), .pgmStart(pgmStart),
    .wrPermit(wrPermit), .wrDiscard(wrDiscard),
    .protActive(protActive), .pageUnlocked(pageUnlocked)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Strobe one write, check the same-cycle verdict, return just after the edge.
  task automatic doWrite(input logic [12:0] a, input logic [7:0] d,
                         input logic expPermit, input logic expDiscard, input string req);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStrobe = 1'b1;
    #2;
    check(req, $sformatf("permit %h@%h", d, a), wrPermit, expPermit);
    check(req, $sformatf("discard %h@%h", d, a), wrDiscard, expDiscard);
    @(posedge clk);
    #1 wrStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic armSeq(input string req);
    doWrite(13'h1555, 8'hAA, 1'b0, 1'b1, req);
    doWrite(13'h0AAA, 8'h55, 1'b0, 1'b1, req);
    doWrite(13'h1555, 8'hA0, 1'b0, 1'b1, req);
  endtask

  task automatic test_reset();
    check("R1", "protActive after reset", protActive, 1'b0);
    check("R1", "pageUnlocked after reset", pageUnlocked, 1'b0);
    doWrite(13'h0010, 8'h12, 1'b1, 1'b0, "R1");
    doWrite(13'h1fff, 8'h80, 1'b1, 1'b0, "R2");
  endtask

  task automatic test_arm_and_session();
    armSeq("R3");
    check("R3", "protActive after prefix", protActive, 1'b1);
    check("R3", "pageUnlocked after prefix", pageUnlocked, 1'b1);
    doWrite(13'h0200, 8'h01, 1'b1, 1'b0, "R6");
    doWrite(13'h0205, 8'h02, 1'b1, 1'b0, "R6");
    doWrite(13'h021f, 8'h03, 1'b1, 1'b0, "R6");
    @(negedge clk); pgmStart = 1'b1;
    @(posedge clk); #1 pgmStart = 1'b0;
    check("R7", "pageUnlocked after pgmStart", pageUnlocked, 1'b0);
    doWrite(13'h0200, 8'h04, 1'b0, 1'b0, "R7");
    doWrite(13'h0300, 8'h05, 1'b0, 1'b0, "R5");
  endtask

  task automatic test_mismatch_protected();
    doWrite(13'h1555, 8'hAA, 1'b0, 1'b1, "R4");
    doWrite(13'h0AAA, 8'h56, 1'b0, 1'b0, "R10");
    doWrite(13'h0AAA, 8'h55, 1'b0, 1'b0, "R10");
    doWrite(13'h1555, 8'hA0, 1'b0, 1'b0, "R10");
    check("R10", "no session after broken prefix", pageUnlocked, 1'b0);
  endtask

  task automatic test_window();
    armSeq("R3");
    idle(BLC - 1);
    doWrite(13'h0400, 8'h11, 1'b1, 1'b0, "R8");
    idle(BLC);
    check("R8", "session closed after gap", pageUnlocked, 1'b0);
    doWrite(13'h0401, 8'h22, 1'b0, 1'b0, "R8");
    doWrite(13'h1555, 8'hAA, 1'b0, 1'b1, "R8");
    doWrite(13'h0AAA, 8'h55, 1'b0, 1'b1, "R8");
    idle(BLC);
    doWrite(13'h1555, 8'hA0, 1'b0, 1'b0, "R8");
    check("R8", "no session after late third byte", pageUnlocked, 1'b0);
  endtask

  task automatic test_warm_reset();
    armSeq("R3");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #2;
    check("R11", "protActive kept over warm reset", protActive, 1'b1);
    check("R11", "session cleared by warm reset", pageUnlocked, 1'b0);
  endtask

  task automatic test_disarm();
    doWrite(13'h1555, 8'hAA, 1'b0, 1'b1, "R9");
    doWrite(13'h0AAA, 8'h55, 1'b0, 1'b1, "R9");
    doWrite(13'h1555, 8'h80, 1'b0, 1'b1, "R9");
    doWrite(13'h1555, 8'hAA, 1'b0, 1'b1, "R9");
    doWrite(13'h0AAA, 8'h55, 1'b0, 1'b1, "R9");
    check("R9", "still protected before sixth", protActive, 1'b1);
    doWrite(13'h1555, 8'h20, 1'b0, 1'b1, "R9");
    check("R9", "protActive after disarm", protActive, 1'b0);
    doWrite(13'h0600, 8'h33, 1'b1, 1'b0, "R9");
  endtask

  task automatic test_mismatch_unprotected();
    doWrite(13'h1555, 8'hAA, 1'b0, 1'b1, "R4");
    doWrite(13'h0100, 8'h12, 1'b1, 1'b0, "R10");
    doWrite(13'h0AAA, 8'h55, 1'b1, 1'b0, "R10");
    check("R10", "flag unchanged", protActive, 1'b0);
  endtask

  task automatic test_cold_reset();
    armSeq("R3");
    check("R11", "armed before cold reset", protActive, 1'b1);
    @(negedge clk); coldRstN = 1'b0; rstN = 1'b0;
    @(negedge clk); coldRstN = 1'b1; rstN = 1'b1;
    #2;
    check("R11", "protActive after cold reset", protActive, 1'b0);
    doWrite(13'h0700, 8'h44, 1'b1, 1'b0, "R11");
  endtask

  initial begin
    idle(3);
    @(negedge clk); coldRstN = 1'b1; rstN = 1'b1;
    idle(1);
    test_reset();
    test_arm_and_session();
    test_mismatch_protected();
    test_window();
    test_warm_reset();
    test_disarm();
    test_mismatch_unprotected();
    test_cold_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule